// File: doc/BRIEF.md
# Two-Role External Bus Hold Arbiter

This block lets a controller share its external memory bus with one other bus master through a three-wire handshake: a hold request, a hold acknowledge and a bus request. A single role input sets which side the controller takes. In the default master role it owns the bus. It hands the bus to an outside requester that raises the hold line, but only after the bus cycle in flight has finished. It then floats its bus drivers and acknowledges. When the requester lets go of hold, it drops the acknowledge and waits a programmable gap before it drives the bus again. While it is holding, it raises its own bus request to ask for the bus back if an internal access is waiting.

In the slave role the acknowledge line turns into an input, so two of these blocks can be wired together pin to pin with no glue logic. The slave raises bus request when it has work to do. It keeps its drivers floated until the other side acknowledges, and it may start cycles only while that acknowledge is present. Both incoming handshake lines pass through a synchroniser chain before any decision uses them. The pin polarity is a parameter. Until arbitration is enabled, the block leaves the bus with the local controller and keeps its handshake outputs inactive.

Top module: `hold_arbiter`

## Requirements
- R1: After reset with arbitration disabled, the acknowledge and bus-request outputs are at their inactive level, the float enable is 0, run-permission is 1 and the acknowledge drive enable is 0.
- R2: While `arb_en_i` is 0, float enable stays 0, run-permission stays 1, and the acknowledge and bus request stay inactive, whatever the hold and acknowledge inputs do.
- R3: In the master role (`slave_sel_i`=0), a hold request is granted at the first clock edge at which the synchronised hold is active and `cycle_done_i` is 1. From that edge on, the acknowledge and the float enable are both active.
- R4: In the master role, run-permission is 0 whenever the synchronised hold is active or the bus is not driven. It falls before the grant, so no new cycle starts while the hold waits for `cycle_done_i`.
- R5: In the master role, once the synchronised hold goes inactive, the acknowledge drops at the next edge. The float enable stays 1 for RELEASE_GAP clock cycles and then returns to 0, and at that point run-permission returns to 1.
- R6: In the master role, bus request is active exactly while the acknowledge is active and `bus_req_i` is 1.
- R7: The acknowledge drive enable `hlda_oe_o` is 1 only when arbitration is enabled in the master role. In the slave role the acknowledge output stays inactive.
- R8: In the slave role, `bus_req_i`=1 raises bus request at the next edge. The float enable stays 1 until the synchronised acknowledge input has been seen at an edge, and only then do run-permission and bus driving begin.
- R9: In the slave role, while the bus is owned, a clock edge with `bus_req_i`=0 and `cycle_done_i`=1 gives up the bus: bus request goes inactive and float enable goes to 1.
- R10: In the slave role, run-permission is 0 whenever the synchronised acknowledge input is inactive. Losing the acknowledge while owning the bus returns the block to the requesting state, or to idle if `bus_req_i` is 0.
- R11: With PIN_ACTIVE_LOW=1, the hold, acknowledge-in, acknowledge-out and bus-request pins are active at logic 0 and idle at logic 1. With 0 they are active high.
- R12: Each handshake input reaches the decision logic through exactly SYNC_STAGES flip-flops. A hold that is raised just after an edge is granted at the (SYNC_STAGES+1)-th edge when `cycle_done_i` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arb_en_i | input | 1 | Arbitration enable |
| slave_sel_i | input | 1 | Role select: 0 master, 1 slave |
| hold_pin_i | input | 1 | Hold request from the other master (pin level) |
| hlda_pin_i | input | 1 | Acknowledge received in the slave role (pin level) |
| bus_req_i | input | 1 | Internal access pending |
| cycle_done_i | input | 1 | No external bus cycle is in flight |
| hlda_pin_o | output | 1 | Acknowledge driven in the master role (pin level) |
| hlda_oe_o | output | 1 | Drive enable for the acknowledge pin |
| breq_pin_o | output | 1 | Bus request (pin level) |
| bus_float_o | output | 1 | Float enable for the address, data and strobe drivers |
| run_ok_o | output | 1 | Local controller may start a bus cycle |

## Verification
The bench builds the arbiter with SYNC_STAGES=2, RELEASE_GAP=2 and PIN_ACTIVE_LOW=1. The active-low pins exercise the polarity inversion in both directions. A gap of two makes the release counter take more than one step, so an off-by-one in the recovery window shows up as a float enable that ends one cycle early or late. Two synchroniser stages put the grant at the third edge after hold rises, and directed checks pin that edge exactly. A randomised run then changes the role, the enable and all handshake inputs while the model is compared on every cycle.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;

   // master-role sequencer states
   typedef enum logic [1:0] {
      MST_OWN     = 2'd0,
      MST_HELD    = 2'd1,
      MST_RECOVER = 2'd2
   } mst_state_e;

   // slave-role sequencer states
   typedef enum logic [1:0] {
      SLV_IDLE = 2'd0,
      SLV_REQ  = 2'd1,
      SLV_OWN  = 2'd2
   } slv_state_e;

   // convert between a logical "active" level and a pin level
   function automatic logic to_pin(input logic active, input bit active_low);
      return active_low ? ~active : active;
   endfunction

endpackage

// File: rtl/hold_arb_sync.sv
// Synchroniser for one asynchronous handshake line.
module hold_arb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 2) begin : g_pair
         logic meta_q;
         logic safe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               meta_q <= 1'b0;
               safe_q <= 1'b0;
            end else begin
               meta_q <= d_i;
               safe_q <= meta_q;
            end
         end
         assign q_o = safe_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], d_i};
            end
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/hold_arb_master.sv
// Master role: the local side owns the bus and lends it out on request.
module hold_arb_master
   import hold_arb_pkg::*;
#(
   parameter int RELEASE_GAP = 1,
   localparam int GAP_W      = (RELEASE_GAP < 2) ? 1 : $clog2(RELEASE_GAP)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,      // role not active: park in the owning state
   input  logic hold_s_i,     // synchronised hold request
   input  logic cycle_done_i,
   input  logic bus_req_i,
   output logic hlda_o,
   output logic breq_o,
   output logic float_o,
   output logic run_ok_o
);

   localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(RELEASE_GAP - 1);

   mst_state_e       state_q, state_d;
   logic [GAP_W-1:0] gap_q, gap_d;

   always_comb begin
      state_d = state_q;
      gap_d   = gap_q;
      unique case (state_q)
         MST_OWN: begin
            // only at a cycle boundary may the bus change hands
            if (hold_s_i && cycle_done_i) begin
               state_d = MST_HELD;
            end
         end
         MST_HELD: begin
            if (!hold_s_i) begin
               state_d = MST_RECOVER;
               gap_d   = '0;
            end
         end
         MST_RECOVER: begin
            if (gap_q == GAP_LAST) begin
               state_d = MST_OWN;
               gap_d   = '0;
            end else begin
               gap_d = gap_q + 1'b1;
            end
         end
         default: begin
            state_d = MST_OWN;
            gap_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MST_OWN;
         gap_q   <= '0;
      end else if (clear_i) begin
         state_q <= MST_OWN;
         gap_q   <= '0;
      end else begin
         state_q <= state_d;
         gap_q   <= gap_d;
      end
   end

   assign hlda_o   = (state_q == MST_HELD);
   assign breq_o   = (state_q == MST_HELD) && bus_req_i;
   assign float_o  = (state_q != MST_OWN);
   // a pending hold blocks new cycles ahead of the grant
   assign run_ok_o = (state_q == MST_OWN) && !hold_s_i;

endmodule

// File: rtl/hold_arb_slave.sv
// Slave role: the local side must be granted the bus before running cycles.
module hold_arb_slave
   import hold_arb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic grant_s_i,    // synchronised acknowledge from the master
   input  logic cycle_done_i,
   input  logic bus_req_i,
   output logic breq_o,
   output logic float_o,
   output logic run_ok_o
);

   slv_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SLV_IDLE: begin
            if (bus_req_i) begin
               state_d = SLV_REQ;
            end
         end
         SLV_REQ: begin
            if (!bus_req_i) begin
               state_d = SLV_IDLE;
            end else if (grant_s_i) begin
               state_d = SLV_OWN;
            end
         end
         SLV_OWN: begin
            if (!grant_s_i) begin
               state_d = bus_req_i ? SLV_REQ : SLV_IDLE;
            end else if (!bus_req_i && cycle_done_i) begin
               state_d = SLV_IDLE;
            end
         end
         default: state_d = SLV_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SLV_IDLE;
      end else if (clear_i) begin
         state_q <= SLV_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   assign breq_o   = (state_q == SLV_REQ) || (state_q == SLV_OWN);
   assign float_o  = (state_q != SLV_OWN);
   assign run_ok_o = (state_q == SLV_OWN) && grant_s_i;

endmodule

// File: rtl/hold_arbiter.sv
module hold_arbiter
   import hold_arb_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter int RELEASE_GAP    = 1,
   parameter bit PIN_ACTIVE_LOW = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arb_en_i,
   input  logic slave_sel_i,
   input  logic hold_pin_i,
   input  logic hlda_pin_i,
   input  logic bus_req_i,
   input  logic cycle_done_i,
   output logic hlda_pin_o,
   output logic hlda_oe_o,
   output logic breq_pin_o,
   output logic bus_float_o,
   output logic run_ok_o
);

   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hold_arbiter: SYNC_STAGES must be at least 2");
   end
   if (RELEASE_GAP < 1) begin : g_bad_gap
      $error("hold_arbiter: RELEASE_GAP must be at least 1");
   end

   // pins to logical levels
   logic hold_lvl, grant_lvl;
   generate
      if (PIN_ACTIVE_LOW) begin : g_in_low
         assign hold_lvl  = ~hold_pin_i;
         assign grant_lvl = ~hlda_pin_i;
      end else begin : g_in_high
         assign hold_lvl  = hold_pin_i;
         assign grant_lvl = hlda_pin_i;
      end
   endgenerate

   logic hold_s, grant_s;

   hold_arb_sync #(.STAGES(SYNC_STAGES)) u_sync_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (hold_lvl),
      .q_o  (hold_s)
   );

   hold_arb_sync #(.STAGES(SYNC_STAGES)) u_sync_grant (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (grant_lvl),
      .q_o  (grant_s)
   );

   logic mst_active, slv_active;
   assign mst_active = arb_en_i && !slave_sel_i;
   assign slv_active = arb_en_i &&  slave_sel_i;

   logic m_hlda, m_breq, m_float, m_run;
   logic s_breq, s_float, s_run;

   hold_arb_master #(.RELEASE_GAP(RELEASE_GAP)) u_master (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (!mst_active),
      .hold_s_i    (hold_s),
      .cycle_done_i(cycle_done_i),
      .bus_req_i   (bus_req_i),
      .hlda_o      (m_hlda),
      .breq_o      (m_breq),
      .float_o     (m_float),
      .run_ok_o    (m_run)
   );

   hold_arb_slave u_slave (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (!slv_active),
      .grant_s_i   (grant_s),
      .cycle_done_i(cycle_done_i),
      .bus_req_i   (bus_req_i),
      .breq_o      (s_breq),
      .float_o     (s_float),
      .run_ok_o    (s_run)
   );

   // logical outputs, role selected
   logic hlda_act, breq_act;

   always_comb begin
      hlda_act    = 1'b0;
      breq_act    = 1'b0;
      bus_float_o = 1'b0;
      run_ok_o    = 1'b1;
      if (mst_active) begin
         hlda_act    = m_hlda;
         breq_act    = m_breq;
         bus_float_o = m_float;
         run_ok_o    = m_run;
      end else if (slv_active) begin
         breq_act    = s_breq;
         bus_float_o = s_float;
         run_ok_o    = s_run;
      end
   end

   assign hlda_oe_o  = mst_active;
   assign hlda_pin_o = to_pin(hlda_act, PIN_ACTIVE_LOW);
   assign breq_pin_o = to_pin(breq_act, PIN_ACTIVE_LOW);

endmodule

// File: rtl/hold_arbiter_chk.sv
module hold_arbiter_chk (
   input logic clk,
   input logic rst_n,
   input logic arb_en_i,
   input logic slave_sel_i,
   input logic cycle_done_i,
   input logic hold_s,
   input logic grant_s,
   input logic hlda_act,
   input logic breq_act,
   input logic hlda_oe_o,
   input logic bus_float_o,
   input logic run_ok_o
);

   // R2
   disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !arb_en_i |-> (!bus_float_o && run_ok_o && !hlda_act && !breq_act));

   // R3
   grant_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hlda_act) |-> ($past(cycle_done_i) && $past(hold_s)));

   // R3
   hlda_floats_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hlda_act |-> bus_float_o);

   // R4
   no_run_while_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_float_o |-> !run_ok_o);

   // R5
   gap_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_en_i && $past(arb_en_i) && !slave_sel_i && !$past(slave_sel_i) && $fell(hlda_act))
      |-> bus_float_o);

   // R6
   breq_only_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_en_i && !slave_sel_i && breq_act) |-> hlda_act);

   // R7
   slave_quiet_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slave_sel_i |-> (!hlda_act && !hlda_oe_o));

   // R10
   slave_run_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_en_i && slave_sel_i && run_ok_o) |-> grant_s);

endmodule

bind hold_arbiter hold_arbiter_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .arb_en_i    (arb_en_i),
   .slave_sel_i (slave_sel_i),
   .cycle_done_i(cycle_done_i),
   .hold_s      (hold_s),
   .grant_s     (grant_s),
   .hlda_act    (hlda_act),
   .breq_act    (breq_act),
   .hlda_oe_o   (hlda_oe_o),
   .bus_float_o (bus_float_o),
   .run_ok_o    (run_ok_o)
);

// File: tb/hold_arbiter_test.sv
module hold_arbiter_test;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC  = 2;
   localparam int GAP   = 2;
   localparam bit ALOW  = 1'b1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arb_en = 1'b0, slave_sel = 1'b0, bus_req = 1'b0, cycle_done = 1'b1;
   logic hold_l = 1'b0, grant_l = 1'b0;   // logical levels
   logic hlda_pin_o, hlda_oe_o, breq_pin_o, bus_float_o, run_ok_o;

   int checks = 0;
   int errors = 0;
   bit done_flag = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hold_arbiter #(.SYNC_STAGES(SYNC), .RELEASE_GAP(GAP), .PIN_ACTIVE_LOW(ALOW)) uut (
      .clk(clk), .rst_n(rst_n), .arb_en_i(arb_en), .slave_sel_i(slave_sel),
      .hold_pin_i(ALOW ? ~hold_l : hold_l), .hlda_pin_i(ALOW ? ~grant_l : grant_l),
      .bus_req_i(bus_req), .cycle_done_i(cycle_done),
      .hlda_pin_o(hlda_pin_o), .hlda_oe_o(hlda_oe_o), .breq_pin_o(breq_pin_o),
      .bus_float_o(bus_float_o), .run_ok_o(run_ok_o));

   // logical view of active-low pins (R11)
   wire hlda_act = ALOW ? ~hlda_pin_o : hlda_pin_o;
   wire breq_act = ALOW ? ~breq_pin_o : breq_pin_o;

   // ---------------- behavioural reference model ----------------
   int hold_hist[$];
   int grant_hist[$];
   int mst;      // 0 own, 1 held, 2 recover
   int gapc;
   int slv;      // 0 idle, 1 requesting, 2 owning
   bit compare_on = 0;

   function automatic int hs_now();  return hold_hist[SYNC-1];  endfunction
   function automatic int gs_now();  return grant_hist[SYNC-1]; endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_hist = {};
         grant_hist = {};
         for (int i = 0; i < SYNC; i++) begin
            hold_hist.push_back(0);
            grant_hist.push_back(0);
         end
         mst = 0; gapc = 0; slv = 0;
      end else begin
         int hs, gs;
         hs = hs_now();
         gs = gs_now();
         void'(hold_hist.pop_back());
         hold_hist.push_front(int'(hold_l));
         void'(grant_hist.pop_back());
         grant_hist.push_front(int'(grant_l));
         if (!arb_en) begin
            mst = 0; gapc = 0; slv = 0;
         end else if (!slave_sel) begin
            slv = 0;
            if (mst == 0) begin
               if (hs != 0 && cycle_done) mst = 1;
            end else if (mst == 1) begin
               if (hs == 0) begin mst = 2; gapc = 0; end
            end else begin
               if (gapc == GAP-1) begin mst = 0; gapc = 0; end
               else gapc++;
            end
         end else begin
            mst = 0; gapc = 0;
            if (slv == 0) begin
               if (bus_req) slv = 1;
            end else if (slv == 1) begin
               if (!bus_req) slv = 0;
               else if (gs != 0) slv = 2;
            end else begin
               if (gs == 0) slv = bus_req ? 1 : 0;
               else if (!bus_req && cycle_done) slv = 0;
            end
         end
      end
   end

   task automatic check1(input logic act, input logic exp, input string tag, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // compare every cycle on the falling edge
   always @(negedge clk) begin
      if (compare_on && rst_n && !done_flag) begin
         logic e_hlda, e_oe, e_breq, e_float, e_run;
         string t_h, t_b, t_f, t_r;
         e_hlda = 0; e_oe = 0; e_breq = 0; e_float = 0; e_run = 1;
         if (!arb_en) begin
            t_h = "R2"; t_b = "R2"; t_f = "R2"; t_r = "R2";
         end else if (!slave_sel) begin
            e_oe = 1;
            e_hlda = (mst == 1);
            e_breq = (mst == 1) && bus_req;
            e_float = (mst != 0);
            e_run = (mst == 0) && (hs_now() == 0);
            t_h = "R3"; t_b = "R6"; t_f = "R5"; t_r = "R4";
         end else begin
            e_breq = (slv != 0);
            e_float = (slv != 2);
            e_run = (slv == 2) && (gs_now() != 0);
            t_h = "R7"; t_b = "R8"; t_f = "R9"; t_r = "R10";
         end
         check1(hlda_act, e_hlda, t_h, "model hlda");
         check1(hlda_oe_o, e_oe, "R7", "model hlda_oe");
         check1(breq_act, e_breq, t_b, "model breq");
         check1(bus_float_o, e_float, t_f, "model float");
         check1(run_ok_o, e_run, t_r, "model run_ok");
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      step(2);
      rst_n = 1'b1;
      step(1);
      compare_on = 1;
      // R1 reset state
      check1(hlda_act, 0, "R1", "reset hlda");
      check1(breq_act, 0, "R1", "reset breq");
      check1(bus_float_o, 0, "R1", "reset float");
      check1(run_ok_o, 1, "R1", "reset run_ok");
      check1(hlda_oe_o, 0, "R1", "reset hlda_oe");
      // R11 inactive pins idle high
      check1(hlda_pin_o, 1, "R11", "idle hlda pin");
      check1(breq_pin_o, 1, "R11", "idle breq pin");

      // R2 disabled: hold ignored
      hold_l = 1; bus_req = 1;
      step(6);
      check1(bus_float_o, 0, "R2", "disabled float");
      check1(run_ok_o, 1, "R2", "disabled run_ok");
      check1(hlda_act, 0, "R2", "disabled hlda");
      hold_l = 0; bus_req = 0;
      step(4);

      // R12/R3 grant timing, master role
      arb_en = 1; cycle_done = 1;
      step(1);
      check1(hlda_oe_o, 1, "R7", "master hlda_oe");
      hold_l = 1;
      step(2);
      check1(run_ok_o, 0, "R4", "hold seen, run blocked");
      check1(hlda_act, 0, "R12", "not granted at edge 2");
      step(1);
      check1(hlda_act, 1, "R12", "granted at edge 3");
      check1(bus_float_o, 1, "R3", "float with grant");
      check1(hlda_pin_o, 0, "R11", "active hlda pin low");
      // R6 bus request while held
      check1(breq_act, 0, "R6", "breq without pending access");
      bus_req = 1;
      #1;
      check1(breq_act, 1, "R6", "breq with pending access");
      check1(breq_pin_o, 0, "R11", "active breq pin low");
      bus_req = 0;
      // R5 release with gap
      hold_l = 0;
      step(3);
      check1(hlda_act, 0, "R5", "ack dropped");
      check1(bus_float_o, 1, "R5", "gap cycle 1");
      step(1);
      check1(bus_float_o, 1, "R5", "gap cycle 2");
      step(1);
      check1(bus_float_o, 0, "R5", "bus driven again");
      check1(run_ok_o, 1, "R5", "run resumes");

      // R3 cycle boundary gating
      cycle_done = 0; hold_l = 1;
      step(6);
      check1(hlda_act, 0, "R3", "held off by busy cycle");
      check1(run_ok_o, 0, "R4", "run blocked while waiting");
      cycle_done = 1;
      step(1);
      check1(hlda_act, 1, "R3", "granted at boundary");
      hold_l = 0;
      step(8);

      // slave role
      slave_sel = 1;
      step(1);
      check1(hlda_oe_o, 0, "R7", "slave hlda_oe");
      bus_req = 1;
      step(1);
      check1(breq_act, 1, "R8", "slave request");
      check1(bus_float_o, 1, "R8", "slave floats before grant");
      grant_l = 1;
      step(2);
      check1(run_ok_o, 0, "R8", "grant not yet used");
      step(1);
      check1(run_ok_o, 1, "R8", "slave runs");
      check1(bus_float_o, 0, "R8", "slave drives");
      // R10 grant lost
      grant_l = 0;
      step(2);
      check1(run_ok_o, 0, "R10", "run stops with grant");
      step(1);
      check1(bus_float_o, 1, "R10", "back to request float");
      check1(breq_act, 1, "R10", "still requesting");
      grant_l = 1;
      step(3);
      check1(bus_float_o, 0, "R10", "owns again");
      // R9 voluntary release
      bus_req = 0; cycle_done = 1;
      step(1);
      check1(breq_act, 0, "R9", "request dropped");
      check1(bus_float_o, 1, "R9", "floats after release");
      grant_l = 0;
      step(4);

      // randomised phase, model compared each cycle
      for (int k = 0; k < 4000; k++) begin
         if ($urandom_range(0, 99) < 3)  arb_en = ~arb_en;
         if ($urandom_range(0, 99) < 2)  slave_sel = ~slave_sel;
         if ($urandom_range(0, 99) < 12) hold_l = ~hold_l;
         if ($urandom_range(0, 99) < 12) grant_l = ~grant_l;
         if ($urandom_range(0, 99) < 20) bus_req = ~bus_req;
         cycle_done = ($urandom_range(0, 99) < 60);
         step(1);
      end
      step(2);
      finish_run();
   end

endmodule